// File: doc/BRIEF.md
# 16-bit Command Frame Serial Slave

This block is the host-facing serial front end of a UART. A host exchanges fixed 16-bit frames with it over a four-wire serial link (SPI mode 0) while holding an active-low select. The first two bits the host shifts in choose one of four operations: load the configuration word, read the configuration word back, hand a byte to the transmitter, or take a byte from the receiver. While the frame runs, the block shifts status and read data back to the host. The select, clock and data input are synchronised into the system clock domain, so edges are found by oversampling and the serial clock must be several times slower than the system clock.

Nothing is committed while the select is low. Side effects happen only when the select rises after exactly 16 serial clock rising edges: the configuration register is loaded, a transmit strobe is issued, or a receive pop is issued. A frame with fewer than 16 edges is dropped with no side effect. Toward the UART core the block presents the configuration word, a transmit byte with a one-cycle strobe, and a one-cycle pop. It takes in the receive-ready and transmit-empty flags and the byte at the head of the receive queue.

Top module: `cmdframe_spi_slave`

## Requirements
- R1: After reset, cfg_o is 0, dout_o is 0, and tx_stb_o and rx_pop_o are low.
- R2: The first two bits of a frame (first bit is the MSB) form the opcode. For opcode 2'b11, the 14 bits that follow (MSB first) are loaded into cfg_o when the select rises after 16 bits. cfg_o changes at no other time.
- R3: In every frame, DOUT carries rx_ready_i (sampled at select fall) before the first rising edge. After the first falling edge it carries tx_empty_i (sampled at select fall). For opcodes 2'b11 and 2'b10 the remaining 14 DOUT bits are 0.
- R4: For opcode 2'b01, DOUT bits 3 to 16 return cfg_o MSB first, and cfg_o is left unchanged.
- R5: For opcode 2'b10, the last 8 bits of the frame appear on tx_byte_o, with tx_stb_o high for exactly one cycle after the select rises.
- R6: For opcode 2'b00, DOUT bits 9 to 16 return rx_byte_i (sampled at select fall) MSB first, and bits 3 to 8 are 0. rx_pop_o pulses for one cycle at commit only if the sampled rx_ready_i was 1.
- R7: A frame with fewer than 16 rising serial clock edges before the select rises changes nothing: no cfg_o update, no strobe, no pop.
- R8: Rising edges after the 16th in a frame are ignored, and the commit uses the first 16 bits.
- R9: A serial clock rising edge that reaches the block in the same cycle as the select rise is not counted.
- R10: While the select is high, serial clock and data activity has no effect, and dout_o is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select from host |
| sclk_i | input | 1 | Serial clock from host, idle low |
| din_i | input | 1 | Serial data from host, captured on rising sclk |
| dout_o | output | 1 | Serial data to host, updated on falling sclk |
| cfg_o | output | CFG_W | Configuration word toward the UART core |
| tx_stb_o | output | 1 | One-cycle strobe, transmit byte valid |
| tx_byte_o | output | DATA_W | Byte for the transmitter |
| rx_pop_o | output | 1 | One-cycle pop of the receive queue head |
| rx_ready_i | input | 1 | Receive data available flag |
| tx_empty_i | input | 1 | Transmitter empty flag |
| rx_byte_i | input | DATA_W | Byte at the head of the receive queue |

## Verification
The collision of interest is the commit on the select rise meeting a serial clock rising edge in the same system cycle. The bench provokes it by driving both pins on the same clock edge. Because both pins pass through equal synchroniser depth, the edges reach the engine together. A 15-bit frame followed by a coincident edge must still abort, and a 16-bit frame with a coincident extra edge must commit its first 16 bits. The bench judges both cases by the cfg_o, strobe and pop counts it observes against its own model.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [1:0] {
        OP_RD_DATA = 2'b00,
        OP_RD_CFG  = 2'b01,
        OP_WR_DATA = 2'b10,
        OP_WR_CFG  = 2'b11
    } cfs_op_e;
endpackage

// File: rtl/cfs_sync.sv
module cfs_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb st_d = d_i;
        end else begin : g_many
            always_comb st_d = {st_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cfs_dout_sel.sv
module cfs_dout_sel
    import cfs_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CFG_W   = 14,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 5
) (
    input  logic [CNT_W-1:0]  pos_i,
    input  cfs_op_e           op_i,
    input  logic              t_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o
);
    localparam int HDR_W  = FRAME_W - CFG_W;
    localparam int DPOS   = FRAME_W - DATA_W;
    localparam int CIDX_W = (CFG_W > 1) ? $clog2(CFG_W) : 1;
    localparam int DIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    always_comb begin
        bit_o = 1'b0;
        if (pos_i == CNT_W'(1)) begin
            bit_o = t_i;
        end else if (pos_i >= CNT_W'(HDR_W) && pos_i < CNT_W'(FRAME_W)) begin
            case (op_i)
                OP_RD_CFG:  bit_o = cfg_i[CIDX_W'(FRAME_W - 1 - int'(pos_i))];
                OP_RD_DATA: if (pos_i >= CNT_W'(DPOS))
                                bit_o = data_i[DIDX_W'(FRAME_W - 1 - int'(pos_i))];
                default:    bit_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cmdframe_spi_slave.sv
module cmdframe_spi_slave
    import cfs_pkg::*;
#(
    parameter int FRAME_W     = 16,
    parameter int CFG_W       = 14,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              tx_stb_o,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic              rx_pop_o,
    input  logic              rx_ready_i,
    input  logic              tx_empty_i,
    input  logic [DATA_W-1:0] rx_byte_i
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int OP_W  = 2;

    typedef struct packed {
        logic              cs_prev;
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [FRAME_W-1:0] sh;
        cfs_op_e           op;
        logic              r_snap;
        logic              t_snap;
        logic [DATA_W-1:0] rxb;
        logic              dout;
        logic [CFG_W-1:0]  cfg;
        logic              tx_stb;
        logic [DATA_W-1:0] tx_byte;
        logic              rx_pop;
    } state_t;

    state_t s_d, s_q;
    logic   cs_s, sclk_s, din_s;
    logic   out_bit;
    logic   cs_fall, cs_rise, sclk_rise, sclk_fall;

    cfs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, sclk_i, din_i}),
        .q_o   ({cs_s, sclk_s, din_s})
    );

    cfs_dout_sel #(.FRAME_W(FRAME_W), .CFG_W(CFG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dsel (
        .pos_i  (s_q.cnt),
        .op_i   (s_q.op),
        .t_i    (s_q.t_snap),
        .cfg_i  (s_q.cfg),
        .data_i (s_q.rxb),
        .bit_o  (out_bit)
    );

    always_comb begin
        cs_fall   = s_q.cs_prev & ~cs_s;
        cs_rise   = ~s_q.cs_prev & cs_s;
        sclk_rise = sclk_s & ~s_q.sclk_prev & ~cs_s;
        sclk_fall = ~sclk_s & s_q.sclk_prev & ~cs_s;

        s_d           = s_q;
        s_d.cs_prev   = cs_s;
        s_d.sclk_prev = sclk_s;
        s_d.tx_stb    = 1'b0;
        s_d.rx_pop    = 1'b0;
        if (cs_s) s_d.dout = 1'b0;

        if (cs_fall) begin
            s_d.cnt    = '0;
            s_d.sh     = '0;
            s_d.op     = OP_RD_DATA;
            s_d.r_snap = rx_ready_i;
            s_d.t_snap = tx_empty_i;
            s_d.rxb    = rx_byte_i;
            s_d.dout   = rx_ready_i;
        end else if (cs_rise) begin
            s_d.cnt = '0;
            if (s_q.cnt == CNT_W'(FRAME_W)) begin
                case (cfs_op_e'(s_q.sh[FRAME_W-1 -: OP_W]))
                    OP_WR_CFG:  s_d.cfg = s_q.sh[CFG_W-1:0];
                    OP_WR_DATA: begin
                        s_d.tx_byte = s_q.sh[DATA_W-1:0];
                        s_d.tx_stb  = 1'b1;
                    end
                    OP_RD_DATA: s_d.rx_pop = s_q.r_snap;
                    default:    ;
                endcase
            end
        end else if (!cs_s) begin
            if (sclk_rise && s_q.cnt < CNT_W'(FRAME_W)) begin
                s_d.sh  = {s_q.sh[FRAME_W-2:0], din_s};
                s_d.cnt = s_q.cnt + CNT_W'(1);
                if (s_q.cnt == CNT_W'(1)) s_d.op = cfs_op_e'({s_q.sh[0], din_s});
            end
            if (sclk_fall) s_d.dout = out_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.cs_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout_o    = s_q.dout;
    assign cfg_o     = s_q.cfg;
    assign tx_stb_o  = s_q.tx_stb;
    assign tx_byte_o = s_q.tx_byte;
    assign rx_pop_o  = s_q.rx_pop;
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
    parameter int CFG_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_i,
    input logic             dout_o,
    input logic [CFG_W-1:0] cfg_o,
    input logic             tx_stb_o,
    input logic             rx_pop_o
);
    AST_CFG_ONLY_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(cs_n_i, 3)) else $error("cfg changed during frame"); // R2
    AST_TX_ONLY_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_o |-> $past(cs_n_i, 3)) else $error("tx strobe during frame"); // R5
    AST_TX_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_o |=> !tx_stb_o) else $error("tx strobe too long"); // R5
    AST_POP_ONLY_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |-> $past(cs_n_i, 3)) else $error("pop during frame"); // R6
    AST_POP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |=> !rx_pop_o) else $error("pop too long"); // R6
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_stb_o, rx_pop_o})) else $error("strobe and pop together"); // R5
    AST_DOUT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !dout_o)
        else $error("dout active while deselected"); // R10
endmodule

bind cmdframe_spi_slave cfs_checker #(.CFG_W(CFG_W)) u_cfs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .dout_o   (dout_o),
    .cfg_o    (cfg_o),
    .tx_stb_o (tx_stb_o),
    .rx_pop_o (rx_pop_o)
);

// File: tb/cmdframe_spi_slave_bench.sv
module cmdframe_spi_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic rx_ready = 1'b0, tx_empty = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic dout, tx_stb, rx_pop;
    logic [13:0] cfg;
    logic [7:0] tx_byte;

    int checks = 0, fails = 0;
    int n_tx = 0, n_pop = 0;
    logic [7:0] last_tx = 8'h00;
    int tx_m = 0, pop_m = 0;
    logic [13:0] cfg_m = 14'h0;
    logic [7:0] last_m = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdframe_spi_slave u_cmdframe_spi_slave (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
        .dout_o(dout), .cfg_o(cfg), .tx_stb_o(tx_stb), .tx_byte_o(tx_byte),
        .rx_pop_o(rx_pop), .rx_ready_i(rx_ready), .tx_empty_i(tx_empty),
        .rx_byte_i(rx_byte)
    );

    always @(posedge clk) if (rst_n) begin
        if (tx_stb) begin n_tx <= n_tx + 1; last_tx <= tx_byte; end
        if (rx_pop) n_pop <= n_pop + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_word(input logic [1:0] op, input logic r, input logic t,
                                             input logic [13:0] c, input logic [7:0] b);
        logic [13:0] tail;
        case (op)
            2'b01:   tail = c;
            2'b00:   tail = {6'b0, b};
            default: tail = 14'b0;
        endcase
        return {r, t, tail};
    endfunction

    // nbits counted rising edges; coin adds one edge coincident with select rise
    task automatic run_frame(input logic [15:0] w, input int nbits, input bit coin,
                             output logic [15:0] got);
        got = 16'h0;
        @(negedge clk); cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            din = (i < 16) ? w[15-i] : 1'($urandom);
            waitc(HALF);
            if (i < 16) got[15-i] = dout;
            sclk = 1'b1;
            waitc(HALF);
            sclk = 1'b0;
        end
        waitc(HALF);
        if (coin) begin sclk = 1'b1; cs_n = 1'b1; waitc(HALF); sclk = 1'b0; end
        else cs_n = 1'b1;
        waitc(10);
    endtask

    task automatic model(input logic [15:0] w, input int nbits, input logic r);
        if (nbits >= 16) begin
            case (w[15:14])
                2'b11: cfg_m = w[13:0];
                2'b10: begin tx_m++; last_m = w[7:0]; end
                2'b00: if (r) pop_m++;
                default: ;
            endcase
        end
    endtask

    task automatic check_side(input string tag);
        chk(cfg == cfg_m, {tag, " cfg"}, 32'(cfg), 32'(cfg_m));
        chk(n_tx == tx_m, {tag, " tx count"}, 32'(n_tx), 32'(tx_m));
        chk(n_pop == pop_m, {tag, " pop count"}, 32'(n_pop), 32'(pop_m));
        if (tx_m > 0) chk(last_tx == last_m, {tag, " tx byte"}, 32'(last_tx), 32'(last_m));
    endtask

    task automatic full(input logic [15:0] w, input int nbits, input bit coin, input string tag);
        logic [15:0] got, ex;
        ex = exp_word(w[15:14], rx_ready, tx_empty, cfg_m, rx_byte);
        run_frame(w, nbits, coin, got);
        if (nbits >= 16) chk(got == ex, {tag, " dout"}, 32'(got), 32'(ex));
        model(w, nbits, rx_ready);
        check_side(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        waitc(4);
        chk(cfg == 14'h0, "R1 reset cfg", 32'(cfg), 0);
        chk(dout == 1'b0, "R1 reset dout", 32'(dout), 0);
        chk(tx_stb == 1'b0 && rx_pop == 1'b0, "R1 reset strobes", 32'({tx_stb, rx_pop}), 0);
        rst_n = 1'b1;
        waitc(4);

        rx_ready = 1'b1; tx_empty = 1'b0;
        full({2'b11, 14'h2A5C}, 16, 1'b0, "R2 R3 write cfg");
        rx_ready = 1'b0; tx_empty = 1'b1;
        full({2'b01, 14'h1234}, 16, 1'b0, "R4 read cfg");
        full({2'b10, 6'h15, 8'hA5}, 16, 1'b0, "R5 R3 write data");
        rx_ready = 1'b1; rx_byte = 8'h3C;
        full({2'b00, 14'h3FFF}, 16, 1'b0, "R6 read data pop");
        rx_ready = 1'b0; rx_byte = 8'hC3;
        full({2'b00, 14'h0000}, 16, 1'b0, "R6 read data no pop");

        full({2'b11, 14'h0F0F}, 10, 1'b0, "R7 short cfg");
        full({2'b10, 6'h00, 8'h77}, 15, 1'b0, "R7 short data");
        rx_ready = 1'b1;
        full({2'b00, 14'h0}, 1, 1'b0, "R7 one bit");

        full({2'b11, 14'h1357}, 19, 1'b0, "R8 extra bits");
        full({2'b11, 14'h0FF0}, 15, 1'b1, "R9 coincident abort");
        full({2'b11, 14'h2468}, 16, 1'b1, "R9 coincident commit");

        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            din = i[0]; sclk = 1'b1; waitc(HALF);
            chk(dout == 1'b0, "R10 idle dout", 32'(dout), 0);
            sclk = 1'b0; waitc(HALF);
        end
        check_side("R10 idle");

        for (int k = 0; k < 48; k++) begin
            logic [15:0] w;
            int nb;
            string tag;
            w = 16'($urandom);
            rx_ready = 1'($urandom); tx_empty = 1'($urandom); rx_byte = 8'($urandom);
            nb = ($urandom % 4 == 0) ? int'($urandom % 16) : 16 + int'($urandom % 3);
            case (w[15:14])
                2'b11: tag = "R2 rand";
                2'b01: tag = "R4 rand";
                2'b10: tag = "R5 rand";
                default: tag = "R6 rand";
            endcase
            if (nb < 16) tag = "R7 rand";
            full(w, nb, 1'($urandom % 5 == 0), tag);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule